// File: doc/BRIEF.md
# Serial Offset Min-Sum Check Row Unit

This block updates one parity-check row of a layered LDPC decoder. The row's messages arrive block-serially, two positions per beat. For each position the unit takes the current a-posteriori value and the check message left by the previous pass over the row, and keeps their difference as the variable message. A sign-magnitude tracker keeps the smallest and second-smallest magnitudes, the position of the smallest, and the parity of all signs. A fixed offset is then subtracted from both magnitudes. Once the last beat of the row has gone through, the stored variable messages are played back two per cycle. Each one is added to its new check message, and the result leaves the unit as the updated a-posteriori value.

The unit has three stages: read (subtract), process (track and correct) and write (replay and add). The variable messages of a row are held in a two-bank store. One bank fills with the next row while the other is replayed. When a row has an odd number of positions, the upstream sequencer lowers the second-lane flag on the last beat, and that lane then takes no part in the row. At the close of a row the unit also emits a compact check record. Memories and block rotation stay outside the unit.

Top module: `osms_row_unit`

## Requirements
- R1: Messages are 7-bit two's complement with one fractional bit. The variable message for each position is app minus old check, saturated to the range -64..63.
- R2: A position's sign is 1 when its variable message is negative; zero counts as positive. Its magnitude is the absolute value, capped at 63.
- R3: The row minimum is the smallest magnitude, and on a tie the lowest position wins. The second minimum is the smallest magnitude among all other positions. When the row has only one position, the second minimum is taken as 127 before correction. The recorded minimum never exceeds the recorded second minimum.
- R4: The offset correction maps a magnitude x to x-OFFSET when x exceeds OFFSET, and to 0 otherwise. The result is capped at 63. The default OFFSET is 1 LSB, which is 0.5. Both recorded magnitudes are corrected values.
- R5: The new check magnitude at the minimum's position is the corrected second minimum; at every other position it is the corrected minimum. Its sign is the XOR of all signs in the row, XORed with the position's own sign.
- R6: The updated app value is the variable message plus the new check message, saturated to -64..63.
- R7: While the second-lane flag is low on a beat, that lane's inputs have no effect. The lane does not count toward the minima, the sign parity or the sign vector. The matching output beat shows `out_l1_o` low and `app1_o` as 0.
- R8: The check record consists of the corrected minimum, the corrected second minimum, the minimum's position, the overall sign and a sign vector. Positions are numbered beat*2+lane, and bit p of the sign vector is position p's sign. Bits beyond the row read 0. `rec_vld_o` pulses for one cycle per row.
- R9: Take the clock edge that samples a row's last input beat. `rec_vld_o` is high in the second cycle after that edge. The output beats begin in the third cycle, come one per cycle in input order, and `out_last_o` marks the final one.
- R10: A row holds at most MAX_BEATS beats (default 8, so 16 positions). The last beat of a row may arrive only while the previous row's replay is idle or on its final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_vld_i | input | 1 | Input beat valid |
| in_l1_i | input | 1 | Second lane of this beat in use |
| in_last_i | input | 1 | Beat closes the row |
| app0_i | input | 7 | App value, lane 0 |
| app1_i | input | 7 | App value, lane 1 |
| chk0_i | input | 7 | Old check message, lane 0 |
| chk1_i | input | 7 | Old check message, lane 1 |
| out_vld_o | output | 1 | Output beat valid |
| out_l1_o | output | 1 | Lane 1 of output beat valid |
| out_last_o | output | 1 | Final output beat of the row |
| app0_o | output | 7 | Updated app value, lane 0 |
| app1_o | output | 7 | Updated app value, lane 1 |
| rec_vld_o | output | 1 | Check record valid pulse |
| rec_min_o | output | 7 | Corrected minimum magnitude |
| rec_min2_o | output | 7 | Corrected second minimum magnitude |
| rec_idx_o | output | 4 | Position of the minimum |
| rec_sgn_o | output | 1 | XOR of all signs in the row |
| rec_signs_o | output | 16 | Per-position sign vector |

## Verification
The assertions guard several properties on every cycle:
- the read-stage subtraction never wraps across the sign boundary;
- the minimum stays ordered against the second minimum, and its position falls inside the row;
- replay starts the cycle after each record;
- row length stays within bounds;
- a new row never closes while the previous replay is still running.

The exact arithmetic can only be shown by the bench's scenarios, which compare against a model of the rules above. That arithmetic covers saturation at both ends, tie handling, the offset floor, the single-position row, garbage on a disabled lane, and the full sign and position pattern of the record. The bench also sweeps every row length from 1 to 16 many times over with varied values.

// File: rtl/osms_pkg.sv
package osms_pkg;
  localparam int unsigned MSG_W = 7;

  typedef logic signed [MSG_W-1:0] msg_t;
  typedef logic [MSG_W-1:0]        mag_t;

  localparam msg_t MSG_MAX = {1'b0, {(MSG_W-1){1'b1}}};
  localparam msg_t MSG_MIN = {1'b1, {(MSG_W-1){1'b0}}};
  localparam mag_t MAG_CAP = {1'b0, {(MSG_W-1){1'b1}}};
  localparam mag_t MAG_INF = '1;

  function automatic msg_t sat_add(msg_t a, msg_t b);
    logic signed [MSG_W:0] s;
    s = {a[MSG_W-1], a} + {b[MSG_W-1], b};
    if (s[MSG_W] != s[MSG_W-1]) return s[MSG_W] ? MSG_MIN : MSG_MAX;
    return s[MSG_W-1:0];
  endfunction

  function automatic msg_t sat_sub(msg_t a, msg_t b);
    logic signed [MSG_W:0] s;
    s = {a[MSG_W-1], a} - {b[MSG_W-1], b};
    if (s[MSG_W] != s[MSG_W-1]) return s[MSG_W] ? MSG_MIN : MSG_MAX;
    return s[MSG_W-1:0];
  endfunction

  // two's complement -> capped magnitude
  function automatic mag_t to_mag(msg_t v);
    mag_t m;
    m = v[MSG_W-1] ? mag_t'(~v + 1'b1) : mag_t'(v);
    return (m > MAG_CAP) ? MAG_CAP : m;
  endfunction

  // sign-magnitude -> two's complement, magnitude assumed <= MAG_CAP
  function automatic msg_t to_msg(logic sgn, mag_t m);
    return sgn ? msg_t'(~m + 1'b1) : msg_t'(m);
  endfunction

  function automatic mag_t offset_fix(mag_t m, mag_t off);
    mag_t r;
    r = (m > off) ? mag_t'(m - off) : '0;
    return (r > MAG_CAP) ? MAG_CAP : r;
  endfunction
endpackage

// File: rtl/osms_read.sv
module osms_read
  import osms_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic l1_i,
  input  logic last_i,
  input  msg_t app0_i,
  input  msg_t app1_i,
  input  msg_t chk0_i,
  input  msg_t chk1_i,
  output logic q_vld_o,
  output logic q_l1_o,
  output logic q_last_o,
  output msg_t q0_o,
  output msg_t q1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_vld_o  <= 1'b0;
      q_l1_o   <= 1'b0;
      q_last_o <= 1'b0;
      q0_o     <= '0;
      q1_o     <= '0;
    end else begin
      q_vld_o  <= vld_i;
      q_l1_o   <= vld_i & l1_i;
      q_last_o <= vld_i & last_i;
      q0_o     <= vld_i ? sat_sub(app0_i, chk0_i) : '0;
      q1_o     <= (vld_i && l1_i) ? sat_sub(app1_i, chk1_i) : '0;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !app0_i[MSG_W-1] && chk0_i[MSG_W-1]) |=> !q0_o[MSG_W-1]); // R1
endmodule

// File: rtl/osms_track.sv
module osms_track
  import osms_pkg::*;
#(
  parameter int unsigned MAX_BEATS = 8,
  parameter int unsigned OFFSET    = 1,
  localparam int unsigned POS = 2 * MAX_BEATS,
  localparam int unsigned IW  = $clog2(POS),
  localparam int unsigned AW  = $clog2(MAX_BEATS),
  localparam int unsigned CW  = $clog2(MAX_BEATS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           q_vld_i,
  input  logic           q_l1_i,
  input  logic           q_last_i,
  input  msg_t           q0_i,
  input  msg_t           q1_i,
  input  logic           rd_bank_i,
  input  logic [AW-1:0]  rd_addr_i,
  output msg_t           rd_q0_o,
  output msg_t           rd_q1_o,
  output logic           rd_l1_o,
  output logic           done_o,
  output mag_t           done_min_o,
  output mag_t           done_min2_o,
  output logic [IW-1:0]  done_idx_o,
  output logic           done_sgn_o,
  output logic [POS-1:0] done_signs_o,
  output logic [CW-1:0]  done_beats_o,
  output logic           done_bank_o
);
  logic           bank_q;
  logic [CW-1:0]  cnt_q;
  mag_t           run_min_q, run_min2_q;
  logic [IW-1:0]  run_idx_q;
  logic           run_sgn_q;
  logic [POS-1:0] run_signs_q;

  msg_t buf0_q [2][MAX_BEATS];
  msg_t buf1_q [2][MAX_BEATS];
  logic bufl1_q[2][MAX_BEATS];

  logic           first;
  mag_t           base_min, base_min2, m0, m1, bmin, bmin2, nmin, nmin2;
  logic [IW-1:0]  base_idx, idx0, idx1, bidx, nidx;
  logic           base_sgn, s0, s1;
  logic [POS-1:0] base_signs, nsigns;

  always_comb begin
    first      = (cnt_q == '0);
    base_min   = first ? MAG_INF : run_min_q;
    base_min2  = first ? MAG_INF : run_min2_q;
    base_idx   = first ? '0 : run_idx_q;
    base_sgn   = first ? 1'b0 : run_sgn_q;
    base_signs = first ? '0 : run_signs_q;

    idx0 = IW'({cnt_q[AW-1:0], 1'b0});
    idx1 = IW'({cnt_q[AW-1:0], 1'b1});
    m0   = to_mag(q0_i);
    s0   = q0_i[MSG_W-1];
    // disabled lane never wins and contributes no sign
    m1   = q_l1_i ? to_mag(q1_i) : MAG_INF;
    s1   = q_l1_i & q1_i[MSG_W-1];

    if (m1 < m0) begin
      bmin = m1; bidx = idx1; bmin2 = m0;
    end else begin
      bmin = m0; bidx = idx0; bmin2 = m1;
    end

    if (bmin < base_min) begin
      nmin  = bmin;
      nidx  = bidx;
      nmin2 = (base_min < bmin2) ? base_min : bmin2;
    end else begin
      nmin  = base_min;
      nidx  = base_idx;
      nmin2 = (bmin < base_min2) ? bmin : base_min2;
    end

    nsigns = base_signs | (POS'(s0) << idx0) | (POS'(s1) << idx1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q      <= 1'b0;
      cnt_q       <= '0;
      run_min_q   <= MAG_INF;
      run_min2_q  <= MAG_INF;
      run_idx_q   <= '0;
      run_sgn_q   <= 1'b0;
      run_signs_q <= '0;
    end else if (q_vld_i) begin
      run_min_q   <= nmin;
      run_min2_q  <= nmin2;
      run_idx_q   <= nidx;
      run_sgn_q   <= base_sgn ^ s0 ^ s1;
      run_signs_q <= nsigns;
      if (q_last_i) begin
        cnt_q  <= '0;
        bank_q <= ~bank_q;
      end else begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (q_vld_i) begin
      buf0_q[bank_q][cnt_q[AW-1:0]]  <= q0_i;
      buf1_q[bank_q][cnt_q[AW-1:0]]  <= q1_i;
      bufl1_q[bank_q][cnt_q[AW-1:0]] <= q_l1_i;
    end
  end

  assign rd_q0_o      = buf0_q[rd_bank_i][rd_addr_i];
  assign rd_q1_o      = buf1_q[rd_bank_i][rd_addr_i];
  assign rd_l1_o      = bufl1_q[rd_bank_i][rd_addr_i];

  assign done_o       = q_vld_i & q_last_i;
  assign done_min_o   = offset_fix(nmin,  mag_t'(OFFSET));
  assign done_min2_o  = offset_fix(nmin2, mag_t'(OFFSET));
  assign done_idx_o   = nidx;
  assign done_sgn_o   = base_sgn ^ s0 ^ s1;
  assign done_signs_o = nsigns;
  assign done_beats_o = cnt_q + CW'(1);
  assign done_bank_o  = bank_q;

  AST_BEAT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_vld_i && !q_last_i) |-> (cnt_q < CW'(MAX_BEATS - 1))); // R10
endmodule

// File: rtl/osms_write.sv
module osms_write
  import osms_pkg::*;
#(
  parameter int unsigned MAX_BEATS = 8,
  localparam int unsigned POS = 2 * MAX_BEATS,
  localparam int unsigned IW  = $clog2(POS),
  localparam int unsigned AW  = $clog2(MAX_BEATS),
  localparam int unsigned CW  = $clog2(MAX_BEATS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           done_i,
  input  mag_t           done_min_i,
  input  mag_t           done_min2_i,
  input  logic [IW-1:0]  done_idx_i,
  input  logic           done_sgn_i,
  input  logic [POS-1:0] done_signs_i,
  input  logic [CW-1:0]  done_beats_i,
  input  logic           done_bank_i,
  output logic           rd_bank_o,
  output logic [AW-1:0]  rd_addr_o,
  input  msg_t           rd_q0_i,
  input  msg_t           rd_q1_i,
  input  logic           rd_l1_i,
  output logic           out_vld_o,
  output logic           out_l1_o,
  output logic           out_last_o,
  output msg_t           app0_o,
  output msg_t           app1_o,
  output logic           rec_vld_o,
  output mag_t           rec_min_o,
  output mag_t           rec_min2_o,
  output logic [IW-1:0]  rec_idx_o,
  output logic           rec_sgn_o,
  output logic [POS-1:0] rec_signs_o
);
  logic          busy_q, bank_q, fin;
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] beats_q;
  logic [IW-1:0] p0, p1;
  mag_t          mg0, mg1;
  msg_t          a0, a1;

  always_comb begin
    fin = busy_q && (CW'(ptr_q) == beats_q - CW'(1));
    p0  = IW'({ptr_q, 1'b0});
    p1  = IW'({ptr_q, 1'b1});
    mg0 = (p0 == rec_idx_o) ? rec_min2_o : rec_min_o;
    mg1 = (p1 == rec_idx_o) ? rec_min2_o : rec_min_o;
    a0  = sat_add(rd_q0_i, to_msg(rec_sgn_o ^ rec_signs_o[p0], mg0));
    a1  = sat_add(rd_q1_i, to_msg(rec_sgn_o ^ rec_signs_o[p1], mg1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      bank_q      <= 1'b0;
      ptr_q       <= '0;
      beats_q     <= '0;
      rec_vld_o   <= 1'b0;
      rec_min_o   <= '0;
      rec_min2_o  <= '0;
      rec_idx_o   <= '0;
      rec_sgn_o   <= 1'b0;
      rec_signs_o <= '0;
    end else begin
      rec_vld_o <= done_i;
      if (done_i) begin
        busy_q      <= 1'b1;
        bank_q      <= done_bank_i;
        ptr_q       <= '0;
        beats_q     <= done_beats_i;
        rec_min_o   <= done_min_i;
        rec_min2_o  <= done_min2_i;
        rec_idx_o   <= done_idx_i;
        rec_sgn_o   <= done_sgn_i;
        rec_signs_o <= done_signs_i;
      end else if (busy_q) begin
        ptr_q <= ptr_q + AW'(1);
        if (fin) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o  <= 1'b0;
      out_l1_o   <= 1'b0;
      out_last_o <= 1'b0;
      app0_o     <= '0;
      app1_o     <= '0;
    end else begin
      out_vld_o  <= busy_q;
      out_l1_o   <= busy_q & rd_l1_i;
      out_last_o <= fin;
      app0_o     <= busy_q ? a0 : '0;
      app1_o     <= (busy_q && rd_l1_i) ? a1 : '0;
    end
  end

  assign rd_bank_o = bank_q;
  assign rd_addr_o = ptr_q;

  AST_ROW_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_q || fin)); // R10
  AST_MIN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |-> (rec_min_o <= rec_min2_o)); // R3
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |-> (int'(rec_idx_o) < 2 * int'(beats_q))); // R8
  AST_REPLAY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |=> out_vld_o); // R9
endmodule

// File: rtl/osms_row_unit.sv
module osms_row_unit
  import osms_pkg::*;
#(
  parameter int unsigned MAX_BEATS = 8,
  parameter int unsigned OFFSET    = 1,
  localparam int unsigned POS = 2 * MAX_BEATS,
  localparam int unsigned IW  = $clog2(POS),
  localparam int unsigned AW  = $clog2(MAX_BEATS),
  localparam int unsigned CW  = $clog2(MAX_BEATS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_vld_i,
  input  logic                    in_l1_i,
  input  logic                    in_last_i,
  input  logic signed [MSG_W-1:0] app0_i,
  input  logic signed [MSG_W-1:0] app1_i,
  input  logic signed [MSG_W-1:0] chk0_i,
  input  logic signed [MSG_W-1:0] chk1_i,
  output logic                    out_vld_o,
  output logic                    out_l1_o,
  output logic                    out_last_o,
  output logic signed [MSG_W-1:0] app0_o,
  output logic signed [MSG_W-1:0] app1_o,
  output logic                    rec_vld_o,
  output logic [MSG_W-1:0]        rec_min_o,
  output logic [MSG_W-1:0]        rec_min2_o,
  output logic [IW-1:0]           rec_idx_o,
  output logic                    rec_sgn_o,
  output logic [POS-1:0]          rec_signs_o
);
  logic           q_vld, q_l1, q_last;
  msg_t           q0, q1;
  logic           rd_bank, rd_l1;
  logic [AW-1:0]  rd_addr;
  msg_t           rd_q0, rd_q1;
  logic           done, done_sgn, done_bank;
  mag_t           done_min, done_min2;
  logic [IW-1:0]  done_idx;
  logic [POS-1:0] done_signs;
  logic [CW-1:0]  done_beats;

  osms_read u_read (
    .clk_i, .rst_ni,
    .vld_i(in_vld_i), .l1_i(in_l1_i), .last_i(in_last_i),
    .app0_i, .app1_i, .chk0_i, .chk1_i,
    .q_vld_o(q_vld), .q_l1_o(q_l1), .q_last_o(q_last),
    .q0_o(q0), .q1_o(q1)
  );

  osms_track #(.MAX_BEATS(MAX_BEATS), .OFFSET(OFFSET)) u_track (
    .clk_i, .rst_ni,
    .q_vld_i(q_vld), .q_l1_i(q_l1), .q_last_i(q_last),
    .q0_i(q0), .q1_i(q1),
    .rd_bank_i(rd_bank), .rd_addr_i(rd_addr),
    .rd_q0_o(rd_q0), .rd_q1_o(rd_q1), .rd_l1_o(rd_l1),
    .done_o(done), .done_min_o(done_min), .done_min2_o(done_min2),
    .done_idx_o(done_idx), .done_sgn_o(done_sgn),
    .done_signs_o(done_signs), .done_beats_o(done_beats),
    .done_bank_o(done_bank)
  );

  osms_write #(.MAX_BEATS(MAX_BEATS)) u_write (
    .clk_i, .rst_ni,
    .done_i(done), .done_min_i(done_min), .done_min2_i(done_min2),
    .done_idx_i(done_idx), .done_sgn_i(done_sgn),
    .done_signs_i(done_signs), .done_beats_i(done_beats),
    .done_bank_i(done_bank),
    .rd_bank_o(rd_bank), .rd_addr_o(rd_addr),
    .rd_q0_i(rd_q0), .rd_q1_i(rd_q1), .rd_l1_i(rd_l1),
    .out_vld_o, .out_l1_o, .out_last_o, .app0_o, .app1_o,
    .rec_vld_o, .rec_min_o, .rec_min2_o, .rec_idx_o, .rec_sgn_o,
    .rec_signs_o
  );
endmodule

// File: tb/osms_row_unit_tb_top.sv
module osms_row_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OFF = 1;
  localparam int MAXP = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_vld_i = 1'b0, in_l1_i = 1'b0, in_last_i = 1'b0;
  logic signed [6:0] app0_i = '0, app1_i = '0, chk0_i = '0, chk1_i = '0;
  logic out_vld_o, out_l1_o, out_last_o, rec_vld_o, rec_sgn_o;
  logic signed [6:0] app0_o, app1_o;
  logic [6:0] rec_min_o, rec_min2_o;
  logic [3:0] rec_idx_o;
  logic [15:0] rec_signs_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  osms_row_unit #(.MAX_BEATS(8), .OFFSET(OFF)) dut_i (
    .clk_i(clk), .rst_ni,
    .in_vld_i, .in_l1_i, .in_last_i,
    .app0_i, .app1_i, .chk0_i, .chk1_i,
    .out_vld_o, .out_l1_o, .out_last_o, .app0_o, .app1_o,
    .rec_vld_o, .rec_min_o, .rec_min2_o, .rec_idx_o, .rec_sgn_o,
    .rec_signs_o
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  int app_a[MAXP], chk_a[MAXP], exp_app[MAXP];
  int e_min, e_min2, e_idx, e_sgn;
  logic [15:0] e_signs;
  int cur_n = 0, cur_nb = 0, ob_cnt = 0, rec_seen = 0, last_cyc = 0;
  string cur_tag = "R6";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(int lo, int hi);
    seed = seed * 32'd1103515245 + 32'd12345;
    return lo + int'((seed >> 16) & 32'h7fff) % (hi - lo + 1);
  endfunction

  function automatic int sat7(int x);
    return (x > 63) ? 63 : ((x < -64) ? -64 : x);
  endfunction

  function automatic int corr(int x);
    int r;
    r = (x > OFF) ? x - OFF : 0;
    return (r > 63) ? 63 : r;
  endfunction

  // reference model of one row
  task automatic model(int n);
    int q[MAXP], m[MAXP], s[MAXP];
    e_min = 127; e_min2 = 127; e_idx = 0; e_sgn = 0; e_signs = '0;
    for (int p = 0; p < n; p++) begin
      q[p] = sat7(app_a[p] - chk_a[p]);
      s[p] = (q[p] < 0) ? 1 : 0;
      m[p] = (q[p] < 0) ? -q[p] : q[p];
      if (m[p] > 63) m[p] = 63;
      e_sgn ^= s[p];
      e_signs[p] = s[p][0];
      if (m[p] < e_min) begin e_min2 = e_min; e_min = m[p]; e_idx = p; end
      else if (m[p] < e_min2) e_min2 = m[p];
    end
    for (int p = 0; p < n; p++) begin
      int mg, sg;
      mg = (p == e_idx) ? corr(e_min2) : corr(e_min);
      sg = e_sgn ^ s[p];
      exp_app[p] = sat7(q[p] + (sg != 0 ? -mg : mg));
    end
  endtask

  task automatic run_row(int n, string tag);
    int nb;
    nb = (n + 1) / 2;
    model(n);
    cur_n = n; cur_nb = nb; ob_cnt = 0; rec_seen = 0; cur_tag = tag;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      in_vld_i  = 1'b1;
      in_l1_i   = (2*b + 1 < n);
      in_last_i = (b == nb - 1);
      app0_i    = 7'(app_a[2*b]);
      chk0_i    = 7'(chk_a[2*b]);
      if (2*b + 1 < n) begin
        app1_i = 7'(app_a[2*b+1]);
        chk1_i = 7'(chk_a[2*b+1]);
      end else begin
        app1_i = 7'(rnd(-64, 63));  // garbage on disabled lane
        chk1_i = 7'(rnd(-64, 63));
      end
      if (b == nb - 1) last_cyc = cyc;
    end
    @(negedge clk);
    in_vld_i = 1'b0; in_l1_i = 1'b0; in_last_i = 1'b0;
    app0_i = '0; app1_i = '0; chk0_i = '0; chk1_i = '0;
    repeat (nb + 5) @(negedge clk);
    check("R9 beat count", ob_cnt, nb);
    check("R8 record pulses", rec_seen, 1);
  endtask

  always @(negedge clk) begin
    if (rst_ni && rec_vld_o) begin
      rec_seen++;
      check("R9 record latency", cyc, last_cyc + 2);
      check("R4 rec_min", int'(rec_min_o), corr(e_min));
      check("R3 rec_min2", int'(rec_min2_o), corr(e_min2));
      check("R3 rec_idx", int'(rec_idx_o), e_idx);
      check("R5 rec_sgn", int'(rec_sgn_o), e_sgn);
      check("R8 rec_signs", int'(rec_signs_o), int'(e_signs));
    end
    if (rst_ni && out_vld_o) begin
      if (ob_cnt == 0) check("R9 output latency", cyc, last_cyc + 3);
      if (ob_cnt < cur_nb) begin
        check({cur_tag, " app0"}, int'(app0_o), exp_app[2*ob_cnt]);
        if (2*ob_cnt + 1 < cur_n) begin
          check("R7 out_l1 set", int'(out_l1_o), 1);
          check({cur_tag, " app1"}, int'(app1_o), exp_app[2*ob_cnt+1]);
        end else begin
          check("R7 out_l1 clear", int'(out_l1_o), 0);
          check("R7 app1 quiet", int'(app1_o), 0);
        end
        check("R9 out_last", int'(out_last_o), (ob_cnt == cur_nb - 1) ? 1 : 0);
      end
      ob_cnt++;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset rec_vld", int'(rec_vld_o), 0);
    check("R9 reset out_vld", int'(out_vld_o), 0);
    check("R8 reset rec_signs", int'(rec_signs_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1: saturation at both ends on subtraction and addition
    app_a[0] = 63;  chk_a[0] = -64;
    app_a[1] = -64; chk_a[1] = 63;
    app_a[2] = 63;  chk_a[2] = -5;
    app_a[3] = -64; chk_a[3] = 5;
    run_row(4, "R1");

    // R2: zero counts as positive, mixed signs
    app_a[0] = 0; app_a[1] = -1; app_a[2] = 1; app_a[3] = -30; app_a[4] = 30; app_a[5] = 0;
    for (int p = 0; p < 6; p++) chk_a[p] = 0;
    chk_a[5] = 1;
    run_row(6, "R2");

    // R4: magnitudes at or below the offset floor to zero
    app_a[0] = 1; app_a[1] = -1; app_a[2] = 0; app_a[3] = 1;
    for (int p = 0; p < 4; p++) chk_a[p] = 0;
    run_row(4, "R4");

    // R3: all equal magnitudes, earliest position wins
    for (int p = 0; p < 5; p++) begin app_a[p] = (p % 2) ? -20 : 20; chk_a[p] = 0; end
    run_row(5, "R3");

    // R3: single position, second minimum is the sentinel
    app_a[0] = -9; chk_a[0] = 3;
    run_row(1, "R3");

    // R7: odd row with garbage on the disabled lane
    for (int p = 0; p < 7; p++) begin app_a[p] = rnd(-40, 40); chk_a[p] = rnd(-20, 20); end
    run_row(7, "R7");

    // R10: longest row
    for (int p = 0; p < 16; p++) begin app_a[p] = rnd(-64, 63); chk_a[p] = rnd(-64, 63); end
    run_row(16, "R10");

    // R5/R6: sweep every length with varied values
    for (int k = 0; k < 160; k++) begin
      int n;
      n = (k % 16) + 1;
      for (int p = 0; p < n; p++) begin
        if (k % 3 == 0) begin app_a[p] = rnd(-8, 8); chk_a[p] = rnd(-4, 4); end
        else begin app_a[p] = rnd(-64, 63); chk_a[p] = rnd(-64, 63); end
      end
      run_row(n, (k % 2) ? "R5" : "R6");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule